// File: doc/BRIEF.md
# Protection Fault and Restart Sequencer

This block sits beside the switching core of an offline flyback controller and decides, once per switching cycle, whether the power switch may keep running. It takes digitized comparator results for four faults: output overvoltage, output undervoltage, hard overcurrent and overtemperature. It also takes flags describing the supply rail, the presence of high input voltage and a one-time option that selects latched or self-restarting overvoltage handling. From these it drives a switching enable, the enable and foldback select of the high-voltage start-up current source, and a code naming the latest fault.

A stopped controller restarts by letting its supply capacitor discharge to the restart level and then recharging it from the start-up source. In latched mode the supply is recycled this way indefinitely, and only removal of the input releases it. An undervoltage blanking timer, counted in system clocks, suppresses the undervoltage check while the output rises after every start.

Top module: `prot_fault_seq`

## Requirements
- R1: After reset, switching is disabled, the fault code is 0 and the sequencer is in the charging phase.
- R2: In the charging phase the start-up source is on only while high input voltage is present and the supply is below the turn-on level. Once the supply reaches turn-on with no overtemperature, switching starts on the next clock.
- R3: The foldback select is high only while the start-up source is on and the supply is below the foldback level.
- R4: Overvoltage stops switching on the strobe that completes OV_CYCLES consecutive strobes with the comparator set. A strobe without it restarts the count.
- R5: Undervoltage stops switching after UV_CYCLES consecutive flagged strobes. It is ignored for BLANK_TICKS clocks after every entry into switching.
- R6: A first overcurrent strobe keeps switching in a warning state. A clean strobe returns to normal, and a second consecutive overcurrent strobe stops switching.
- R7: After a self-restarting stop, switching and the start-up source stay off until the supply falls below the restart level. Charging follows, then switching at turn-on.
- R8: With the latch option set, an overvoltage stop recycles the supply. The source turns on once the supply is below restart and turns off at turn-on. Switching stays off until high input voltage is absent while the supply is below restart.
- R9: Overtemperature stops switching within one clock and recycles the supply as in R8. When it clears, switching resumes at once if the supply is above UVLO. Otherwise the sequencer waits for the restart level and recharges.
- R10: The fault code holds the latest cause: 0 none, 1 overvoltage, 2 undervoltage, 3 overcurrent, 4 overtemperature.
- R11: When several faults stop the block in one clock, the cause recorded is chosen in the order overtemperature, overvoltage, overcurrent, undervoltage.
- R12: A supply below UVLO while switching, with no fault, stops switching and returns to charging, leaving the fault code unchanged.
- R13: Switching enable and start-up source enable are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One-clock pulse per switching cycle, qualifying the comparator inputs |
| ovp_hit | input | 1 | Output overvoltage comparator result |
| uvp_hit | input | 1 | Output undervoltage comparator result |
| ocp_hit | input | 1 | Hard overcurrent comparator result |
| ot_hot | input | 1 | Overtemperature flag, with hysteresis applied outside |
| vdd_at_on | input | 1 | Supply at or above turn-on level |
| vdd_below_rst | input | 1 | Supply below restart level |
| vdd_below_uvlo | input | 1 | Supply below UVLO level |
| vdd_below_fold | input | 1 | Supply below foldback level |
| hv_present | input | 1 | High input voltage above start-up level |
| latch_sel | input | 1 | 1 selects latched overvoltage handling |
| sw_en | output | 1 | Switching enable |
| hv_src_en | output | 1 | Start-up current source enable |
| hv_src_fold | output | 1 | Start-up source reduced-current select |
| fault_code | output | 3 | Latest fault cause |

## Verification
Two stop causes can land on the same strobe. The bench provokes this twice. First, an overtemperature flag is raised on the fourth consecutive overvoltage strobe, and the bench expects code 4. Second, the second overcurrent strike coincides with the fourth undervoltage strobe once blanking has ended, and the bench expects code 3 with switching off. A randomized overvoltage stream with a fixed seed checks the consecutive-count rule against a counter kept in the bench after every strobe.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;
  localparam int FC_W = 3;

  typedef enum logic [2:0] {
    ST_CHARGE = 3'd0,
    ST_RUN    = 3'd1,
    ST_OCWARN = 3'd2,
    ST_HOLD   = 3'd3,
    ST_LATCH  = 3'd4,
    ST_OTP    = 3'd5
  } seq_st_e;

  typedef enum logic [FC_W-1:0] {
    FC_NONE = 3'd0,
    FC_OV   = 3'd1,
    FC_UV   = 3'd2,
    FC_OC   = 3'd3,
    FC_OT   = 3'd4
  } fault_e;
endpackage

// File: rtl/prot_consec.sv
module prot_consec #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic hit,
  output logic trip
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  localparam logic [CW-1:0] TOP  = CW'(N);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)
      cnt_d = '0;
    else if (stb) begin
      if (!hit)
        cnt_d = '0;
      else if (cnt_q != TOP)
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign trip = en && stb && hit && (cnt_q == LAST);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/prot_blank_tmr.sv
module prot_blank_tmr #(
  parameter int TICKS = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R5
  blank_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/prot_src_ctl.sv
module prot_src_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic charge_st,
  input  logic recycle_st,
  input  logic hv_ok,
  input  logic vdd_on,
  input  logic vdd_rst_lo,
  input  logic vdd_fold_lo,
  output logic src_en,
  output logic src_fold
);
  logic rechg_q, rechg_d;

  always_comb begin
    rechg_d = rechg_q;
    if (vdd_rst_lo)
      rechg_d = 1'b1;
    else if (vdd_on)
      rechg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rechg_q <= 1'b0;
    else
      rechg_q <= rechg_d;
  end

  assign src_en   = hv_ok && !vdd_on && (charge_st || (recycle_st && rechg_q));
  assign src_fold = src_en && vdd_fold_lo;

  // R3
  fold_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_fold |-> src_en);
  // R2
  src_off_at_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_on |-> !src_en);
endmodule

// File: rtl/prot_fault_seq.sv
module prot_fault_seq
  import prot_seq_pkg::*;
#(
  parameter int OV_CYCLES   = 4,
  parameter int UV_CYCLES   = 4,
  parameter int BLANK_TICKS = 2000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_stb,
  input  logic            ovp_hit,
  input  logic            uvp_hit,
  input  logic            ocp_hit,
  input  logic            ot_hot,
  input  logic            vdd_at_on,
  input  logic            vdd_below_rst,
  input  logic            vdd_below_uvlo,
  input  logic            vdd_below_fold,
  input  logic            hv_present,
  input  logic            latch_sel,
  output logic            sw_en,
  output logic            hv_src_en,
  output logic            hv_src_fold,
  output logic [FC_W-1:0] fault_code
);
  logic rs_meta_q, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  seq_st_e st_q, st_d;
  fault_e  fc_q, fc_d;
  logic    run_like, blank_start, blank_done;
  logic    ov_trip, uv_trip, oc_stop;

  assign run_like = (st_q == ST_RUN) || (st_q == ST_OCWARN);

  prot_consec #(.N(OV_CYCLES)) u_ov_cnt (
    .clk(clk), .rst_n(rs_n), .en(run_like), .stb(cyc_stb),
    .hit(ovp_hit), .trip(ov_trip)
  );

  prot_consec #(.N(UV_CYCLES)) u_uv_cnt (
    .clk(clk), .rst_n(rs_n), .en(run_like && blank_done), .stb(cyc_stb),
    .hit(uvp_hit), .trip(uv_trip)
  );

  prot_blank_tmr #(.TICKS(BLANK_TICKS)) u_blank (
    .clk(clk), .rst_n(rs_n), .start(blank_start), .done(blank_done)
  );

  prot_src_ctl u_src (
    .clk(clk), .rst_n(rs_n),
    .charge_st(st_q == ST_CHARGE),
    .recycle_st((st_q == ST_LATCH) || (st_q == ST_OTP)),
    .hv_ok(hv_present), .vdd_on(vdd_at_on), .vdd_rst_lo(vdd_below_rst),
    .vdd_fold_lo(vdd_below_fold),
    .src_en(hv_src_en), .src_fold(hv_src_fold)
  );

  assign oc_stop = (st_q == ST_OCWARN) && cyc_stb && ocp_hit;

  always_comb begin
    st_d        = st_q;
    fc_d        = fc_q;
    blank_start = 1'b0;
    unique case (st_q)
      ST_CHARGE: begin
        if (vdd_at_on && !ot_hot) begin
          st_d        = ST_RUN;
          blank_start = 1'b1;
        end
      end
      ST_RUN, ST_OCWARN: begin
        if (ot_hot) begin
          st_d = ST_OTP;
          fc_d = FC_OT;
        end else if (ov_trip) begin
          st_d = latch_sel ? ST_LATCH : ST_HOLD;
          fc_d = FC_OV;
        end else if (oc_stop) begin
          st_d = ST_HOLD;
          fc_d = FC_OC;
        end else if (uv_trip) begin
          st_d = ST_HOLD;
          fc_d = FC_UV;
        end else if (vdd_below_uvlo) begin
          st_d = ST_CHARGE;
        end else if (cyc_stb) begin
          st_d = ocp_hit ? ST_OCWARN : ST_RUN;
        end
      end
      ST_HOLD: begin
        if (vdd_below_rst)
          st_d = ST_CHARGE;
      end
      ST_LATCH: begin
        if (!hv_present && vdd_below_rst)
          st_d = ST_CHARGE;
      end
      ST_OTP: begin
        if (!ot_hot) begin
          if (vdd_below_uvlo)
            st_d = ST_HOLD;
          else begin
            st_d        = ST_RUN;
            blank_start = 1'b1;
          end
        end
      end
      default: st_d = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q <= ST_CHARGE;
      fc_q <= FC_NONE;
    end else begin
      st_q <= st_d;
      fc_q <= fc_d;
    end
  end

  assign sw_en      = run_like;
  assign fault_code = fc_q;

  // R13
  sw_src_excl_chk: assert property (@(posedge clk) disable iff (!rs_n)
    sw_en |-> !hv_src_en);
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (st_q == ST_LATCH && hv_present) |=> !sw_en);
  // R9
  ot_stop_chk: assert property (@(posedge clk) disable iff (!rs_n)
    ot_hot |=> !sw_en);
  // R5
  uv_after_blank_chk: assert property (@(posedge clk) disable iff (!rs_n)
    blank_start |=> !uv_trip);
endmodule

// File: tb/prot_fault_seq_bench.sv
module prot_fault_seq_bench;
  localparam int BLANK = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc_stb, ovp_hit, uvp_hit, ocp_hit, ot_hot;
  logic vdd_at_on, vdd_below_rst, vdd_below_uvlo, vdd_below_fold;
  logic hv_present, latch_sel;
  logic sw_en, hv_src_en, hv_src_fold;
  logic [2:0] fault_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  prot_fault_seq #(.OV_CYCLES(4), .UV_CYCLES(4), .BLANK_TICKS(BLANK)) u_prot_fault_seq (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ovp_hit(ovp_hit),
    .uvp_hit(uvp_hit), .ocp_hit(ocp_hit), .ot_hot(ot_hot),
    .vdd_at_on(vdd_at_on), .vdd_below_rst(vdd_below_rst),
    .vdd_below_uvlo(vdd_below_uvlo), .vdd_below_fold(vdd_below_fold),
    .hv_present(hv_present), .latch_sel(latch_sel),
    .sw_en(sw_en), .hv_src_en(hv_src_en), .hv_src_fold(hv_src_fold),
    .fault_code(fault_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic ov, input logic uv, input logic oc);
    cyc_stb = 1'b1; ovp_hit = ov; uvp_hit = uv; ocp_hit = oc;
    tick();
    cyc_stb = 1'b0; ovp_hit = 1'b0; uvp_hit = 1'b0; ocp_hit = 1'b0;
  endtask

  // discharge to restart level, then recharge to turn-on
  task automatic power_cycle();
    vdd_at_on = 1'b0; vdd_below_rst = 1'b1;
    tick();
    vdd_below_rst = 1'b0; vdd_at_on = 1'b1;
    tick();
  endtask

  function automatic bit ov_expect_run(input int cnt);
    return cnt < 4;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ovc;
    rst_n = 1'b0;
    cyc_stb = 0; ovp_hit = 0; uvp_hit = 0; ocp_hit = 0; ot_hot = 0;
    vdd_at_on = 0; vdd_below_rst = 1; vdd_below_uvlo = 1; vdd_below_fold = 1;
    hv_present = 0; latch_sel = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 sw_en", sw_en, 0);
    chk("R1 fault_code", fault_code, 0);
    chk("R1 src without hv", hv_src_en, 0);

    // R2 / R3 start-up source and foldback
    hv_present = 1; #1;
    chk("R2 src on", hv_src_en, 1);
    chk("R3 fold low supply", hv_src_fold, 1);
    vdd_below_fold = 0; #1;
    chk("R3 fold released", hv_src_fold, 0);
    vdd_below_rst = 0; vdd_below_uvlo = 0; vdd_at_on = 1; #1;
    chk("R2 src off at turn-on", hv_src_en, 0);
    tick();
    chk("R2 switching after turn-on", sw_en, 1);

    // R5 blanking: undervoltage ignored
    repeat (6) strobe(0, 1, 0);
    chk("R5 uv blanked", sw_en, 1);
    repeat (BLANK + 5) tick();
    repeat (3) strobe(0, 1, 0);
    strobe(0, 0, 0);
    chk("R5 uv run broken", sw_en, 1);
    repeat (3) strobe(0, 1, 0);
    chk("R5 uv three", sw_en, 1);
    strobe(0, 1, 0);
    chk("R5 uv trips", sw_en, 0);
    chk("R10 code uv", fault_code, 2);

    // R7 auto-restart hold
    repeat (3) tick();
    chk("R7 held off", sw_en, 0);
    chk("R7 src off while held", hv_src_en, 0);
    vdd_at_on = 0; vdd_below_rst = 1;
    tick();
    chk("R7 charging after restart level", hv_src_en, 1);
    vdd_below_rst = 0; vdd_at_on = 1;
    tick();
    chk("R7 resumed", sw_en, 1);
    repeat (4) strobe(0, 1, 0);
    chk("R5 blank rearmed", sw_en, 1);

    // R6 overcurrent two-strike
    strobe(0, 0, 1);
    chk("R6 first strike runs", sw_en, 1);
    strobe(0, 0, 0);
    strobe(0, 0, 1);
    chk("R6 strike after clean", sw_en, 1);
    strobe(0, 0, 1);
    chk("R6 second strike stops", sw_en, 0);
    chk("R10 code oc", fault_code, 3);
    power_cycle();

    // R4 overvoltage directed
    repeat (3) strobe(1, 0, 0);
    strobe(0, 0, 0);
    repeat (3) strobe(1, 0, 0);
    chk("R4 ov three", sw_en, 1);
    strobe(1, 0, 0);
    chk("R4 ov trips", sw_en, 0);
    chk("R10 code ov", fault_code, 1);
    power_cycle();

    // R4 random overvoltage stream
    void'($urandom(32'd91));
    ovc = 0;
    for (int i = 0; i < 150; i++) begin
      logic ov;
      ov = (($urandom % 10) < 6);
      strobe(ov, 0, 0);
      ovc = ov ? ovc + 1 : 0;
      chk("R4 random ov", sw_en, ov_expect_run(ovc));
      if (!ov_expect_run(ovc)) begin
        power_cycle();
        ovc = 0;
      end
    end

    // R8 latched overvoltage
    latch_sel = 1;
    repeat (4) strobe(1, 0, 0);
    chk("R8 latched stop", sw_en, 0);
    chk("R8 src off above restart", hv_src_en, 0);
    vdd_at_on = 0; vdd_below_rst = 1;
    tick();
    chk("R8 recycle on", hv_src_en, 1);
    vdd_below_rst = 0; vdd_at_on = 1;
    tick();
    chk("R8 recycle off", hv_src_en, 0);
    chk("R8 still latched", sw_en, 0);
    vdd_at_on = 0; vdd_below_rst = 1;
    tick();
    chk("R8 recycle again", hv_src_en, 1);
    chk("R8 latched with hv", sw_en, 0);
    hv_present = 0;
    tick();
    hv_present = 1; #1;
    chk("R8 released to charge", hv_src_en, 1);
    vdd_below_rst = 0; vdd_at_on = 1;
    tick();
    chk("R8 runs after release", sw_en, 1);
    latch_sel = 0;

    // R9 overtemperature, direct resume
    ot_hot = 1;
    tick();
    chk("R9 ot stop", sw_en, 0);
    chk("R10 code ot", fault_code, 4);
    vdd_at_on = 0; vdd_below_rst = 1;
    tick();
    chk("R9 recycle", hv_src_en, 1);
    vdd_below_rst = 0; vdd_at_on = 1;
    ot_hot = 0;
    tick();
    chk("R9 direct resume", sw_en, 1);

    // R9 resume via discharge when below UVLO
    ot_hot = 1;
    tick();
    vdd_at_on = 0; vdd_below_uvlo = 1;
    ot_hot = 0;
    tick();
    chk("R9 waits below uvlo", sw_en, 0);
    chk("R9 src off in wait", hv_src_en, 0);
    vdd_below_rst = 1;
    tick();
    chk("R9 recharge", hv_src_en, 1);
    vdd_below_rst = 0; vdd_below_uvlo = 0; vdd_at_on = 1;
    tick();
    chk("R9 resumed", sw_en, 1);

    // R12 UVLO while switching
    vdd_below_uvlo = 1; vdd_at_on = 0;
    tick();
    chk("R12 stop on uvlo", sw_en, 0);
    chk("R12 charging", hv_src_en, 1);
    chk("R12 code kept", fault_code, 4);
    vdd_below_uvlo = 0; vdd_at_on = 1;
    tick();
    chk("R12 resume", sw_en, 1);

    // R11 coincidences: overtemperature with fourth ov strike
    repeat (3) strobe(1, 0, 0);
    ot_hot = 1;
    strobe(1, 0, 0);
    chk("R11 ot over ov", fault_code, 4);
    ot_hot = 0;
    tick();
    chk("R11 resume after ot", sw_en, 1);

    // R11 coincidence: second oc strike with fourth uv strobe
    repeat (BLANK + 5) tick();
    strobe(0, 1, 1);
    strobe(0, 1, 0);
    strobe(0, 1, 1);
    chk("R11 still running", sw_en, 1);
    strobe(0, 1, 1);
    chk("R11 stopped", sw_en, 0);
    chk("R11 oc over uv", fault_code, 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule